// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block recovers 8-bit characters from an asynchronous serial line. It is clocked at 16 times the bit rate, so one clock is one sample tick. The line is registered once, and a four-sample history of that register supports the hold-time checks. The receiver checks the idle level before a start bit, the width of the start bit and the stop bit. A good frame produces the assembled byte together with a done strobe. A malformed frame raises an error flag, which clears once the line has been quiet and high again.

The done strobe and the byte last a fixed 16 ticks. A timer separate from the frame sequencer counts them, so they survive when the next start bit follows the stop bit at once. The error flag also stays high without a break when a failed frame runs straight into a line that is still low. Dropping the enable input stops the sequencer and clears every output on the next tick.

Top module: `uart_os_rx`

## Requirements
- R1: During and directly after reset, `busy`, `done` and `err` are low and `data` is zero.
- R2: A falling edge of the registered line starts a frame only if the four samples before it were all high. Otherwise `err` is raised or kept high, and `busy` stays low.
- R3: After an accepted falling edge, the line must stay low for 12 more ticks. If a high sample arrives earlier, `err` rises and `busy` falls two clocks after the high level is applied to `rxd`.
- R4: `err` falls on the fifth clock after `rxd` is driven high, which is when four consecutive high samples have been seen. It stays high before then.
- R5: Data bits are sampled in the middle of their bit periods, least significant bit first. The first data bit after the start bit lands in bit 0 of `data`.
- R6: For a frame with a clean stop bit, `done` rises 151 clocks after the start bit's falling edge is applied to `rxd`.
- R7: The stop bit is accepted on the first tick at which the stop-bit counter is 8 or more and the last four samples are high. If the stop bit goes high at stop-tick 9, `done` rises 158 clocks after the start edge. A one-tick low at stop-tick 3 moves the rise to 153 clocks. A stop bit that goes high at stop-tick 10 or later gives an `err` pulse and no `done`.
- R8: `done` stays high for exactly 16 clocks. During that time `data` holds the received byte without change. At all other times `data` is zero.
- R9: A start bit that begins right after a stop bit does not shorten the pending `done` pulse, and the second byte is received correctly.
- R10: When a failed stop bit is followed by a line that stays low, `err` stays high with no low cycle until the line returns high.
- R11: `busy` is high from the second clock after an accepted start edge is applied, through the data, stop and done phases, and low when idle.
- R12: With `en` low, `busy`, `done` and `err` are low and `data` is zero from the next clock on. Frames that arrive while `en` is low produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, 16 ticks per bit |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Receive enable; low clears and halts the receiver |
| rxd | input | 1 | Asynchronous serial line, high when idle |
| data | output | 8 | Received byte while `done` is high, zero otherwise |
| done | output | 1 | High for 16 ticks after a valid stop bit |
| busy | output | 1 | High while a frame or its done period is in progress |
| err | output | 1 | Malformed start or stop seen; clears after 4 high samples |

## Verification
The bench goes after the stop-bit window at its edges: a high level from stop-tick 9 must still be accepted and one from stop-tick 10 must not. A design whose deadline is off by one tick would accept or reject the wrong case. Back-to-back frames check that the 16-tick done pulse is not cut short when a new start bit arrives during it; a design that ties done to the sequencer state would give a short pulse. The tests also cover start glitches, low-high-low patterns and a two-tick high between lows, so that a receiver with a short idle check or a one-tick error gap is exposed. The clear point of the error flag is checked to the exact clock.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

    // Sequencer states; idle keeps the encoding 3'b001
    typedef enum logic [2:0] {
        RX_RESET = 3'b000,
        RX_IDLE  = 3'b001,
        RX_START = 3'b010,
        RX_DATA  = 3'b011,
        RX_STOP  = 3'b100,
        RX_READY = 3'b101
    } rx_state_e;

endpackage

// File: rtl/uart_os_rx_sampler.sv
module uart_os_rx_sampler #(
    parameter int TAPS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic smp,
    output logic prior_hold,
    output logic cur_hold
);

    logic            smp_d, smp_q;
    logic [TAPS-1:0] hist_d, hist_q;

    always_comb begin
        smp_d  = rxd;
        hist_d = {hist_q[TAPS-2:0], smp_q};
    end

    // Reset to the idle (high) level of the line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q  <= 1'b1;
            hist_q <= '1;
        end else begin
            smp_q  <= smp_d;
            hist_q <= hist_d;
        end
    end

    assign smp        = smp_q;
    // Hold window strictly before the current sample
    assign prior_hold = &hist_q;
    // Hold window ending with the current sample
    assign cur_hold   = smp_q & (&hist_q[TAPS-2:0]);

endmodule

// File: rtl/uart_os_rx_hold.sv
module uart_os_rx_hold #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    output logic active
);

    localparam int HW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam int RW = HW + 1;

    typedef struct packed {
        logic          act;
        logic [HW-1:0] cnt;
    } hold_t;

    hold_t d, q;

    always_comb begin
        d = q;
        if (clr) begin
            d.act = 1'b0;
            d.cnt = '0;
        end else if (load) begin
            d.act = 1'b1;
            d.cnt = '0;
        end else if (q.act) begin
            if (q.cnt == HW'(HOLD - 1)) begin
                d.act = 1'b0;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active = q.act;

    // Checker: length of the current active run
    logic [RW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (load)   run_q <= '0;
        else if (q.act)  run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    // R8
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.act) && !$past(clr)) |-> (run_q == RW'(HOLD)));

    // R8
    hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.act) |-> $past(load));

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int DATA_BITS = 8,
    parameter int HOLD_TAPS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 rxd,
    output logic [DATA_BITS-1:0] data,
    output logic                 done,
    output logic                 busy,
    output logic                 err
);

    localparam int CW         = $clog2(OSR);
    localparam int BW         = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int START_LOAD = OSR / 4;
    localparam int STOP_MIN   = OSR / 2;
    localparam int MID_AT     = OSR / 2 + START_LOAD - 1;
    localparam int LAST       = OSR - 1;

    typedef struct packed {
        rx_state_e            st;
        logic [CW-1:0]        cnt;
        logic [BW-1:0]        bitn;
        logic [DATA_BITS-1:0] shreg;
        logic [DATA_BITS-1:0] outb;
        logic                 err;
    } rx_regs_t;

    rx_regs_t d, q;
    logic smp, prior_hold, cur_hold;
    logic accept, done_w;

    uart_os_rx_sampler #(.TAPS(HOLD_TAPS)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd        (rxd),
        .smp        (smp),
        .prior_hold (prior_hold),
        .cur_hold   (cur_hold)
    );

    uart_os_rx_hold #(.HOLD(OSR)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!en),
        .load   (accept),
        .active (done_w)
    );

    always_comb begin
        d      = q;
        accept = 1'b0;
        if (!en) begin
            d.st   = RX_IDLE;
            d.cnt  = '0;
            d.bitn = '0;
            d.err  = 1'b0;
        end else begin
            unique case (q.st)
                RX_RESET: d.st = RX_IDLE;
                RX_IDLE: begin
                    if (!smp) begin
                        if (prior_hold) begin
                            d.st  = RX_START;
                            d.cnt = CW'(START_LOAD);
                        end else begin
                            d.err = 1'b1;
                        end
                    end else if (cur_hold) begin
                        d.err = 1'b0;
                    end
                end
                RX_START: begin
                    if (smp) begin
                        d.st  = RX_IDLE;
                        d.err = 1'b1;
                        d.cnt = '0;
                    end else if (q.cnt == CW'(LAST)) begin
                        d.st   = RX_DATA;
                        d.cnt  = '0;
                        d.bitn = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (q.cnt == CW'(MID_AT))
                        d.shreg = {smp, q.shreg[DATA_BITS-1:1]};
                    if (q.cnt == CW'(LAST)) begin
                        d.cnt = '0;
                        if (q.bitn == BW'(DATA_BITS - 1)) d.st = RX_STOP;
                        else                              d.bitn = q.bitn + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cur_hold && (q.cnt >= CW'(STOP_MIN))) begin
                        d.st   = RX_READY;
                        d.outb = q.shreg;
                        d.cnt  = '0;
                        accept = 1'b1;
                    end else if (q.cnt == CW'(LAST)) begin
                        d.st  = RX_IDLE;
                        d.err = 1'b1;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_READY: begin
                    if (!smp && prior_hold) begin
                        d.st  = RX_START;
                        d.cnt = CW'(START_LOAD);
                    end else if (!done_w) begin
                        d.st = RX_IDLE;
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= RX_RESET;
        end else begin
            q <= d;
        end
    end

    assign done = done_w;
    assign data = done_w ? q.outb : '0;
    assign busy = (q.st != RX_IDLE) && (q.st != RX_RESET);
    assign err  = q.err;

    // R12
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy && !done && !err && (data == '0)));

    // R2
    start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_START && $past(q.st) == RX_IDLE) |-> $past(prior_hold));

    // R4
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> (!$past(en) || $past(cur_hold)));

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cur_hold));

    // R8
    data_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(data));

    // R11
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

// File: tb/tb_uart_os_rx.sv
module tb_uart_os_rx;

    localparam int DONE_LAT   = 151;
    localparam int LATE_LAT   = 158;
    localparam int GLITCH_LAT = 153;
    localparam int NVEC       = 6;
    // {byte, idle ticks after the stop bit}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h4514, 16'hA500, 16'h0000, 16'hFF05, 16'h8000, 16'h011E
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] data;
    logic       done, busy, err;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    uart_os_rx dut (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .rxd   (rxd),
        .data  (data),
        .done  (done),
        .busy  (busy),
        .err   (err)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor of done pulses and err transitions
    int  pulses = 0, run = 0, unstable = 0, err_falls = 0, err_rises = 0;
    int  rec_data [64];
    int  rec_len  [64];
    int  rec_rise [64];
    int  cap = 0;
    bit  prev_done = 1'b0, prev_err = 1'b0;

    always @(negedge clk) begin
        if (done) begin
            if (!prev_done) begin
                run = 1;
                cap = int'(data);
                if (pulses < 64) rec_rise[pulses] = cyc;
            end else begin
                run = run + 1;
                if (int'(data) != cap) unstable = unstable + 1;
            end
        end else if (prev_done) begin
            if (pulses < 64) begin
                rec_len[pulses]  = run;
                rec_data[pulses] = cap;
            end
            pulses = pulses + 1;
        end
        if (prev_err && !err) err_falls = err_falls + 1;
        if (!prev_err && err) err_rises = err_rises + 1;
        prev_done = done;
        prev_err  = err;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drives one 160-tick frame; stop-bit ticks in [lo_a, lo_b) are low
    task automatic send_frame(input logic [7:0] b, input int lo_a, input int lo_b,
                              output int edge_at);
        edge_at = cyc;
        for (int t = 0; t < 160; t++) begin
            int bi, ph;
            bi = t / 16;
            ph = t % 16;
            if (bi == 0)      rxd = 1'b0;
            else if (bi <= 8) rxd = b[bi-1];
            else              rxd = (ph >= lo_a && ph < lo_b) ? 1'b0 : 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int k, e, p0, f0, r0;
        int edges [NVEC];

        en = 1'b1;
        step(3);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 err in reset", int'(err), 0);
        chk("R1 data in reset", int'(data), 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 err after reset", int'(err), 0);
        step(8);

        // Table walk: clean frames, several back to back
        p0 = pulses;
        r0 = err_rises;
        for (int i = 0; i < NVEC; i++) begin
            send_frame(VEC[i][15:8], 0, 0, edges[i]);
            rxd = 1'b1;
            step(int'(VEC[i][7:0]));
        end
        step(40);
        #1;
        chk("R9 pulse count", pulses - p0, NVEC);
        chk("R8 data stable", unstable, 0);
        chk("R2 no err on clean frames", err_rises - r0, 0);
        for (int i = 0; i < NVEC; i++) begin
            chk("R5 byte", rec_data[p0+i], int'(VEC[i][15:8]));
            chk("R8 R9 done length", rec_len[p0+i], 16);
            chk("R6 done latency", rec_rise[p0+i] - edges[i], DONE_LAT);
        end
        @(negedge clk);
        chk("R8 data zero idle", int'(data), 0);

        // R11 and R3: accepted edge, then early high at tick 6
        k = cyc;
        rxd = 1'b0;
        step(1);
        chk("R11 busy one clock after edge", int'(busy), 0);
        step(1);
        chk("R11 busy two clocks after edge", int'(busy), 1);
        step(4);
        rxd = 1'b1;                       // at k+6
        step(1);
        chk("R3 err before early high seen", int'(err), 0);
        chk("R11 busy in start", int'(busy), 1);
        step(1);
        chk("R3 err on early high", int'(err), 1);
        chk("R3 busy dropped", int'(busy), 0);
        step(2);                          // k+10
        chk("R4 err held before 4 highs", int'(err), 1);
        step(1);                          // k+11
        chk("R4 err cleared after 4 highs", int'(err), 0);
        step(6);

        // R2: error, two-tick high, low again: no start, err continuous
        rxd = 1'b0;
        step(2);
        rxd = 1'b1;
        step(2);
        rxd = 1'b0;
        step(2);
        #1;
        f0 = err_falls;
        @(negedge clk);
        chk("R2 err after short high", int'(err), 1);
        step(8);
        chk("R2 busy without idle hold", int'(busy), 0);
        chk("R2 err stays high", int'(err), 1);
        #1;
        chk("R2 no err gap", err_falls - f0, 0);
        @(negedge clk);
        rxd = 1'b1;
        step(8);

        // R3: low-high-low glitch inside the start bit
        rxd = 1'b0;
        step(3);
        rxd = 1'b1;
        step(1);
        rxd = 1'b0;
        step(1);
        chk("R3 glitch err", int'(err), 1);
        chk("R3 glitch busy", int'(busy), 0);
        rxd = 1'b1;
        step(10);
        chk("R4 err cleared after glitch", int'(err), 0);

        // R7: stop high from tick 9 (accepted late), tick 10 (rejected), glitch
        p0 = pulses;
        send_frame(8'h3C, 0, 9, e);
        rxd = 1'b1;
        step(30);
        #1;
        chk("R7 late stop accepted", pulses - p0, 1);
        chk("R7 late stop byte", rec_data[p0], 8'h3C);
        chk("R7 late stop latency", rec_rise[p0] - e, LATE_LAT);
        @(negedge clk);
        p0 = pulses;
        r0 = err_rises;
        send_frame(8'h5A, 0, 10, e);
        rxd = 1'b1;
        step(30);
        #1;
        chk("R7 too late stop no done", pulses - p0, 0);
        chk("R7 too late stop err", err_rises - r0, 1);
        @(negedge clk);
        p0 = pulses;
        send_frame(8'hD2, 3, 4, e);
        rxd = 1'b1;
        step(30);
        #1;
        chk("R7 stop glitch byte", rec_data[p0], 8'hD2);
        chk("R7 stop glitch latency", rec_rise[p0] - e, GLITCH_LAT);
        @(negedge clk);

        // R10: failed stop into a line held low
        p0 = pulses;
        f0 = err_falls;
        send_frame(8'hC3, 0, 16, e);
        rxd = 1'b0;
        step(40);
        chk("R10 err high", int'(err), 1);
        #1;
        chk("R10 no err gap", err_falls - f0, 0);
        chk("R10 no done", pulses - p0, 0);
        @(negedge clk);
        rxd = 1'b1;
        step(10);
        chk("R4 err cleared after failed frame", int'(err), 0);

        // R12: drop enable during done
        p0 = pulses;
        send_frame(8'h96, 0, 0, e);
        rxd = 1'b1;
        chk("R12 done before disable", int'(done), 1);
        en = 1'b0;
        step(1);
        chk("R12 done cleared", int'(done), 0);
        chk("R12 data cleared", int'(data), 0);
        chk("R12 busy cleared", int'(busy), 0);
        step(2);
        #1;
        chk("R12 truncated pulse", rec_len[p0], 10);
        @(negedge clk);
        p0 = pulses;
        send_frame(8'h33, 0, 0, e);
        rxd = 1'b1;
        chk("R12 busy while disabled", int'(busy), 0);
        step(30);
        #1;
        chk("R12 frame ignored", pulses - p0, 0);
        @(negedge clk);
        en = 1'b1;
        step(10);
        p0 = pulses;
        send_frame(8'h7E, 0, 0, e);
        rxd = 1'b1;
        step(30);
        #1;
        chk("R5 byte after re-enable", rec_data[p0], 8'h7E);
        chk("R6 latency after re-enable", rec_rise[p0] - e, DONE_LAT);

        finish_run();
    end

endmodule